// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block keeps a small number of recent virtual-to-physical page translations and searches all of them at once. A lookup presents a virtual page number, a process identifier and a read/write flag. One cycle later the block answers with the frame number and the protection bits on a hit. On a miss it raises a refill request that carries the page number and process identifier. An external table walker resolves the miss and hands back an entry, which the block installs. If the install displaces a live entry, the block reports that entry's modified bit on a write-back output so the page table can be kept current.

Two ways of sharing the buffer between processes are supported, chosen by a configuration input. In tagged mode a stored process identifier must equal the lookup's identifier. In untagged mode the identifier is ignored, and software clears the buffer with a flush at each context switch. A flush invalidates every entry in one cycle. Dirty entries that it drops are then reported one per cycle on the write-back output. Clean entries produce no write-back.

Top module: `xlate_buf`

## Requirements
- R1: Every lookup (`lk_valid`=1) is answered exactly one cycle later with `rsp_valid`=1. `rsp_hit` is 1 when some valid entry's page number equals `lk_vpn`, subject to R9.
- R2: On a hit, `rsp_pfn` and `rsp_prot` carry the matching entry's frame number and protection bits. On a miss, and in cycles with no response, both are zero.
- R3: A lookup that misses raises `refill_req` one cycle later, with `refill_vpn` and `refill_pid` equal to the looked-up page number and process identifier. `rsp_hit` is 0 in that cycle.
- R4: A fill (`fill_valid`=1 without `flush`) installs the entry at the clock edge, so a lookup in the following cycle hits it.
- R5: The fill target is the lowest-index entry that is invalid and owes no write-back. When there is no such entry, a round-robin pointer picks the target. The pointer starts at 0 after reset and advances by one, wrapping, only when it is used.
- R6: A fill that replaces a valid entry, or an invalid entry still owing a write-back, raises `wb_valid` one cycle later. `wb_vpn`, `wb_pid` and `wb_mod` carry the replaced entry's page number, identifier and modified bit. For an entry still owing a write-back, `wb_mod` is 1.
- R7: A write lookup (`lk_write`=1) that hits an entry whose protection bit 1 (write permission) is set marks that entry modified. Bit 0 is read permission and bit 2 is execute permission; neither has any effect here.
- R8: A write lookup that hits an entry with protection bit 1 clear returns `rsp_fault`=1 together with `rsp_hit`=1, and leaves the entry's modified bit unchanged.
- R9: With `cfg_pid_match`=1, a hit also requires the stored process identifier to equal `lk_pid`. With `cfg_pid_match`=0, identifiers are ignored.
- R10: `flush` invalidates all entries at the clock edge, so later lookups miss. A fill presented in the same cycle as a flush is dropped.
- R11: Each entry that is valid and modified when flushed produces exactly one write-back with `wb_mod`=1. These are emitted one per cycle, lowest index first, starting the cycle after the flush. A write-back caused by a fill takes precedence and delays them. Flushed clean entries produce no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pid_match | input | 1 | 1: process identifier must match; 0: identifier ignored |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vpn | input | VPN_W (20) | Lookup virtual page number |
| lk_pid | input | PID_W (4) | Lookup process identifier |
| fill_valid | input | 1 | Install an entry from the walker |
| fill_vpn | input | VPN_W (20) | Page number of the new entry |
| fill_pid | input | PID_W (4) | Process identifier of the new entry |
| fill_pfn | input | PFN_W (20) | Frame number of the new entry |
| fill_prot | input | PROT_W (3) | Protection bits: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_fault | output | 1 | Write to a write-protected entry |
| rsp_pfn | output | PFN_W (20) | Frame number on a hit |
| rsp_prot | output | PROT_W (3) | Protection bits on a hit |
| refill_req | output | 1 | Miss: walker should fetch this translation |
| refill_vpn | output | VPN_W (20) | Page number that missed |
| refill_pid | output | PID_W (4) | Process identifier that missed |
| wb_valid | output | 1 | Modified bit write-back present |
| wb_vpn | output | VPN_W (20) | Page number being written back |
| wb_pid | output | PID_W (4) | Process identifier being written back |
| wb_mod | output | 1 | Modified bit being written back |

## Verification
The hardest state to reach is a fill that arrives while every entry is either live or flushed-but-still-owing a write-back. Only then does the round-robin pointer land on a pending entry. The eviction write-back must then pre-empt the drain of the flushed dirty entries. The stimulus builds it on purpose: it fills all eight entries with writable pages, dirties every one with write lookups, flushes, and presents a fill on the very next cycle. A reference model in the bench tracks valid, modified, pending and pointer state, so the exact write-back order is predicted. Long random runs in both matching modes then mix lookups, fills and occasional flushes.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  // Protection bit positions inside an entry's protection field
  localparam int PROT_RD_BIT = 0;
  localparam int PROT_WR_BIT = 1;
  localparam int PROT_EX_BIT = 2;

  // Source of the write-back presented in a given cycle
  typedef enum logic [1:0] {
    WB_NONE  = 2'd0,
    WB_EVICT = 2'd1,
    WB_DRAIN = 2'd2
  } wb_src_e;
endpackage

// File: rtl/xb_prienc.sv
module xb_prienc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set index wins
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xb_match.sv
module xb_match #(
  parameter int N     = 8,
  parameter int VPN_W = 20,
  parameter int PID_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tag_en,
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][VPN_W-1:0] vpn_tbl,
  input  logic [N-1:0][PID_W-1:0] pid_tbl,
  input  logic [VPN_W-1:0]        key_vpn,
  input  logic [PID_W-1:0]        key_pid,
  output logic [N-1:0]            hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && (vpn_tbl[g] == key_vpn) &&
                    (!tag_en || (pid_tbl[g] == key_pid));
  end

  // R1: the walker never installs a duplicate, so at most one comparator fires
  assert_single_match_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
endmodule

// File: rtl/xb_victim.sv
module xb_victim #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  free_vec,
  input  logic          take,
  output logic [IW-1:0] idx
);
  logic          any_free;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] rr;

  xb_prienc #(.N(N), .IW(IW)) u_free (
    .req  (free_vec),
    .found(any_free),
    .idx  (free_idx)
  );

  assign idx = any_free ? free_idx : rr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr <= '0;
    end else if (take && !any_free) begin
      rr <= (rr == IW'(N - 1)) ? '0 : rr + 1'b1;
    end
  end

  // R5: a free slot, when one exists, is the one chosen
  assert_victim_free_R5: assert property (@(posedge clk) disable iff (rst)
    any_free |-> free_vec[idx]);

  // R5: pointer moves only when it picked the victim
  assert_rr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(take && !any_free) |=> $stable(rr));
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf #(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int PID_W  = 4,
  parameter int PFN_W  = 20,
  parameter int PROT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_pid_match,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic              lk_write,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PROT_W-1:0] fill_prot,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [PROT_W-1:0] rsp_prot,
  output logic              refill_req,
  output logic [VPN_W-1:0]  refill_vpn,
  output logic [PID_W-1:0]  refill_pid,
  output logic              wb_valid,
  output logic [VPN_W-1:0]  wb_vpn,
  output logic [PID_W-1:0]  wb_pid,
  output logic              wb_mod
);
  import xlate_pkg::*;

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  // entry payload (no reset, written through one port)
  logic [N-1:0][VPN_W-1:0]  e_vpn;
  logic [N-1:0][PID_W-1:0]  e_pid;
  logic [N-1:0][PFN_W-1:0]  e_pfn;
  logic [N-1:0][PROT_W-1:0] e_prot;
  // per-entry status flags
  logic [N-1:0] e_vld, e_mod, e_pend;
  logic [N-1:0] vld_n, mod_n, pend_n;

  logic [N-1:0]      hit_vec;
  logic              hit_any;
  logic [IW-1:0]     hit_idx;
  logic [PROT_W-1:0] sel_prot;
  logic              wr_ok;
  logic [N-1:0]      set_mask, mod_cur;
  logic [N-1:0]      free_vec, vic_oh, drain_oh;
  logic [IW-1:0]     vic_idx, dr_idx;
  logic              dr_found;
  logic              do_fill;
  wb_src_e           wb_src;

  // ---------------- parallel compare ----------------
  xb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_match (
    .clk    (clk),
    .rst    (rst),
    .tag_en (cfg_pid_match),
    .vld    (e_vld),
    .vpn_tbl(e_vpn),
    .pid_tbl(e_pid),
    .key_vpn(lk_vpn),
    .key_pid(lk_pid),
    .hit    (hit_vec)
  );

  xb_prienc #(.N(N), .IW(IW)) u_hit_enc (
    .req  (hit_vec),
    .found(hit_any),
    .idx  (hit_idx)
  );

  assign sel_prot = e_prot[hit_idx];
  assign wr_ok    = sel_prot[PROT_WR_BIT];
  assign set_mask = (lk_valid && lk_write && hit_any && wr_ok) ? (N'(1) << hit_idx) : '0;
  assign mod_cur  = e_mod | set_mask;

  // ---------------- victim and drain selection ----------------
  assign free_vec = ~e_vld & ~e_pend;
  assign do_fill  = fill_valid && !flush;

  xb_victim #(.N(N), .IW(IW)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .free_vec(free_vec),
    .take    (do_fill),
    .idx     (vic_idx)
  );

  xb_prienc #(.N(N), .IW(IW)) u_drain_enc (
    .req  (e_pend),
    .found(dr_found),
    .idx  (dr_idx)
  );

  always_comb begin
    if (do_fill && (e_vld[vic_idx] || e_pend[vic_idx])) wb_src = WB_EVICT;
    else if (dr_found)                                  wb_src = WB_DRAIN;
    else                                                wb_src = WB_NONE;
  end

  assign vic_oh   = do_fill ? (N'(1) << vic_idx) : '0;
  assign drain_oh = (wb_src == WB_DRAIN) ? (N'(1) << dr_idx) : '0;

  always_comb begin
    if (flush) begin
      vld_n  = '0;
      mod_n  = '0;
      pend_n = (e_pend & ~drain_oh) | (e_vld & mod_cur);
    end else begin
      vld_n  = e_vld | vic_oh;
      mod_n  = mod_cur & ~vic_oh;
      pend_n = e_pend & ~drain_oh & ~vic_oh;
    end
  end

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      e_vld  <= '0;
      e_mod  <= '0;
      e_pend <= '0;
    end else begin
      e_vld  <= vld_n;
      e_mod  <= mod_n;
      e_pend <= pend_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      e_vpn[vic_idx]  <= fill_vpn;
      e_pid[vic_idx]  <= fill_pid;
      e_pfn[vic_idx]  <= fill_pfn;
      e_prot[vic_idx] <= fill_prot;
    end
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_pfn    <= '0;
      rsp_prot   <= '0;
      refill_req <= 1'b0;
      refill_vpn <= '0;
      refill_pid <= '0;
      wb_valid   <= 1'b0;
      wb_vpn     <= '0;
      wb_pid     <= '0;
      wb_mod     <= 1'b0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_valid && hit_any;
      rsp_fault  <= lk_valid && lk_write && hit_any && !wr_ok;
      rsp_pfn    <= (lk_valid && hit_any) ? e_pfn[hit_idx] : '0;
      rsp_prot   <= (lk_valid && hit_any) ? sel_prot : '0;
      refill_req <= lk_valid && !hit_any;
      if (lk_valid) begin
        refill_vpn <= lk_vpn;
        refill_pid <= lk_pid;
      end
      wb_valid <= (wb_src != WB_NONE);
      unique case (wb_src)
        WB_EVICT: begin
          wb_vpn <= e_vpn[vic_idx];
          wb_pid <= e_pid[vic_idx];
          wb_mod <= e_vld[vic_idx] ? mod_cur[vic_idx] : 1'b1;
        end
        WB_DRAIN: begin
          wb_vpn <= e_vpn[dr_idx];
          wb_pid <= e_pid[dr_idx];
          wb_mod <= 1'b1;
        end
        default: begin
          wb_vpn <= wb_vpn;
          wb_pid <= wb_pid;
          wb_mod <= 1'b0;
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  assert_refill_is_miss_R3: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> (rsp_valid && !rsp_hit));

  assert_fill_installs_R4: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !flush) |=> ($countones(e_vld) >= 1));

  assert_fault_on_hit_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_hit);

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (e_vld == '0));

  assert_drain_shrinks_R11: assert property (@(posedge clk) disable iff (rst)
    !flush |=> ($countones(e_pend) <= $past($countones(e_pend))));

  assert_clean_wb_evict_R11: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_mod) |-> $past(fill_valid && !flush));
endmodule

// File: tb/sim_xlate_buf.sv
module sim_xlate_buf;
  localparam int N  = 8;
  localparam int VW = 20;
  localparam int PW = 4;
  localparam int FW = 20;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst;
  always #4 clk = ~clk;

  logic          cfg_pid_match, flush, lk_valid, lk_write, fill_valid;
  logic [VW-1:0] lk_vpn, fill_vpn;
  logic [PW-1:0] lk_pid, fill_pid;
  logic [FW-1:0] fill_pfn;
  logic [RW-1:0] fill_prot;
  logic          rsp_valid, rsp_hit, rsp_fault, refill_req, wb_valid, wb_mod;
  logic [FW-1:0] rsp_pfn;
  logic [RW-1:0] rsp_prot;
  logic [VW-1:0] refill_vpn, wb_vpn;
  logic [PW-1:0] refill_pid, wb_pid;

  xlate_buf #(.N(N), .VPN_W(VW), .PID_W(PW), .PFN_W(FW), .PROT_W(RW)) u0 (
    .clk(clk), .rst(rst), .cfg_pid_match(cfg_pid_match), .flush(flush),
    .lk_valid(lk_valid), .lk_write(lk_write), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_pfn(fill_pfn), .fill_prot(fill_prot),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_pfn(rsp_pfn), .rsp_prot(rsp_prot),
    .refill_req(refill_req), .refill_vpn(refill_vpn), .refill_pid(refill_pid),
    .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_pid(wb_pid), .wb_mod(wb_mod)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string ctx    = "R1";

  // reference model state
  logic          m_vld[N], m_mod[N], m_pend[N];
  logic [VW-1:0] m_vpn[N];
  logic [PW-1:0] m_pid[N];
  logic [FW-1:0] m_pfn[N];
  logic [RW-1:0] m_prot[N];
  int            m_rr;

  // expected outputs
  logic          x_rv, x_hit, x_fault, x_rf, x_wbv, x_wbmod;
  logic [FW-1:0] x_pfn;
  logic [RW-1:0] x_prot;
  logic [VW-1:0] x_rfvpn, x_wbvpn;
  logic [PW-1:0] x_rfpid, x_wbpid;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (case %s) act=%0h exp=%0h t=%0t", req, ctx, act, exp, $time);
    end
  endtask

  function automatic bit present(input logic [VW-1:0] vpn, input logic [PW-1:0] pid);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_vpn[i] == vpn && (!cfg_pid_match || m_pid[i] == pid)) return 1;
    return 0;
  endfunction

  // model one clock edge from the driven inputs, then compare outputs
  task automatic tick();
    int   h, d, v;
    logic mc[N];
    h = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_vld[i] && m_vpn[i] == lk_vpn && (!cfg_pid_match || m_pid[i] == lk_pid)) h = i;
    x_rv    = lk_valid;
    x_hit   = lk_valid && (h >= 0);
    x_fault = x_hit && lk_write && !m_prot[h][1];
    x_pfn   = x_hit ? m_pfn[h] : '0;
    x_prot  = x_hit ? m_prot[h] : '0;
    x_rf    = lk_valid && (h < 0);
    x_rfvpn = lk_vpn;
    x_rfpid = lk_pid;
    mc = m_mod;
    if (x_hit && lk_write && m_prot[h][1]) mc[h] = 1'b1;
    d = -1;
    for (int i = N - 1; i >= 0; i--) if (m_pend[i]) d = i;
    x_wbv = 1'b0;
    x_wbmod = 1'b0;
    if (flush) begin
      if (d >= 0) begin
        x_wbv = 1; x_wbvpn = m_vpn[d]; x_wbpid = m_pid[d]; x_wbmod = 1; m_pend[d] = 0;
      end
      for (int i = 0; i < N; i++) begin
        if (m_vld[i] && mc[i]) m_pend[i] = 1;
        m_vld[i] = 0;
        mc[i] = 0;
      end
    end else if (fill_valid) begin
      v = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_vld[i] && !m_pend[i]) v = i;
      if (v < 0) begin v = m_rr; m_rr = (m_rr + 1) % N; end
      if (m_vld[v] || m_pend[v]) begin
        x_wbv = 1; x_wbvpn = m_vpn[v]; x_wbpid = m_pid[v];
        x_wbmod = m_vld[v] ? mc[v] : 1'b1;
      end else if (d >= 0) begin
        x_wbv = 1; x_wbvpn = m_vpn[d]; x_wbpid = m_pid[d]; x_wbmod = 1; m_pend[d] = 0;
      end
      m_vld[v] = 1; mc[v] = 0; m_pend[v] = 0;
      m_vpn[v] = fill_vpn; m_pid[v] = fill_pid; m_pfn[v] = fill_pfn; m_prot[v] = fill_prot;
    end else if (d >= 0) begin
      x_wbv = 1; x_wbvpn = m_vpn[d]; x_wbpid = m_pid[d]; x_wbmod = 1; m_pend[d] = 0;
    end
    m_mod = mc;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == x_rv && rsp_hit == x_hit, "R1 hit", {30'd0, rsp_valid, rsp_hit}, {30'd0, x_rv, x_hit});
    chk(rsp_pfn == x_pfn && rsp_prot == x_prot, "R2 pfn/prot", {9'd0, rsp_prot, rsp_pfn}, {9'd0, x_prot, x_pfn});
    chk(refill_req == x_rf, "R3 refill", 32'(refill_req), 32'(x_rf));
    if (x_rf) chk(refill_vpn == x_rfvpn && refill_pid == x_rfpid, "R3 refill fields",
                  {8'd0, refill_pid, refill_vpn}, {8'd0, x_rfpid, x_rfvpn});
    chk(rsp_fault == x_fault, "R8 fault", 32'(rsp_fault), 32'(x_fault));
    chk(wb_valid == x_wbv, "R6 wb_valid", 32'(wb_valid), 32'(x_wbv));
    if (x_wbv) chk(wb_vpn == x_wbvpn && wb_pid == x_wbpid && wb_mod == x_wbmod, "R6 wb fields",
                   {7'd0, wb_mod, wb_pid, wb_vpn}, {7'd0, x_wbmod, x_wbpid, x_wbvpn});
  endtask

  task automatic idle_in();
    flush = 0; lk_valid = 0; lk_write = 0; lk_vpn = '0; lk_pid = '0;
    fill_valid = 0; fill_vpn = '0; fill_pid = '0; fill_pfn = '0; fill_prot = '0;
  endtask

  task automatic look(input logic [VW-1:0] vpn, input logic [PW-1:0] pid, input logic wr);
    idle_in(); lk_valid = 1; lk_vpn = vpn; lk_pid = pid; lk_write = wr; tick();
  endtask

  task automatic fill(input logic [VW-1:0] vpn, input logic [PW-1:0] pid,
                      input logic [FW-1:0] pfn, input logic [RW-1:0] prot);
    idle_in(); fill_valid = 1; fill_vpn = vpn; fill_pid = pid; fill_pfn = pfn; fill_prot = prot; tick();
  endtask

  task automatic do_flush();
    idle_in(); flush = 1; tick();
  endtask

  task automatic idle();
    idle_in(); tick();
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (case %s)", ctx);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_mod[i] = 0; m_pend[i] = 0;
      m_vpn[i] = '0; m_pid[i] = '0; m_pfn[i] = '0; m_prot[i] = '0;
    end
    m_rr = 0;
    idle_in();
    cfg_pid_match = 1;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: all outputs low (R1)
    chk(!rsp_valid && !rsp_hit && !refill_req && !wb_valid && rsp_pfn == '0, "R1 reset",
        {27'd0, rsp_valid, rsp_hit, refill_req, wb_valid, |rsp_pfn}, 32'd0);
    rst = 0;

    // R4/R5: fill all entries into free slots in index order
    ctx = "R4";
    for (int i = 0; i < N; i++)
      fill(VW'(32'h100 + i), 4'd1, FW'(32'h5000 + i), (i % 2 == 0) ? 3'b011 : 3'b001);
    for (int i = 0; i < N; i++) look(VW'(32'h100 + i), 4'd1, 1'b0);

    // R9: tagged mode rejects another process, untagged accepts it
    ctx = "R9";
    look(20'h100, 4'd2, 1'b0);
    cfg_pid_match = 0;
    look(20'h100, 4'd2, 1'b0);
    look(20'h999, 4'd2, 1'b0);
    cfg_pid_match = 1;

    // R7/R8: dirty a writable entry, fault on a read-only one
    ctx = "R7";
    look(20'h100, 4'd1, 1'b1);
    ctx = "R8";
    look(20'h101, 4'd1, 1'b1);

    // R5/R6: buffer full, pointer picks 0 then 1; write-backs carry mod 1 then 0
    ctx = "R5";
    fill(20'h200, 4'd1, 20'h6000, 3'b011);
    fill(20'h201, 4'd1, 20'h6001, 3'b011);
    look(20'h200, 4'd1, 1'b0);

    // R10/R11: dirty entries 2 and 4, flush with a fill in the same cycle
    ctx = "R11";
    look(20'h102, 4'd1, 1'b1);
    look(20'h104, 4'd1, 1'b1);
    ctx = "R10";
    idle_in(); flush = 1; fill_valid = 1; fill_vpn = 20'h777; fill_pid = 4'd1;
    fill_pfn = 20'h1; fill_prot = 3'b011; tick();
    look(20'h777, 4'd1, 1'b0);
    look(20'h103, 4'd1, 1'b0);
    ctx = "R11";
    idle(); idle();

    // R11/R6: every entry dirty, flush, fill at once -> eviction pre-empts drain
    for (int i = 0; i < N; i++) fill(VW'(32'h300 + i), 4'd3, FW'(32'h7000 + i), 3'b111);
    for (int i = 0; i < N; i++) look(VW'(32'h300 + i), 4'd3, 1'b1);
    do_flush();
    fill(20'h400, 4'd3, 20'h8000, 3'b011);
    fill(20'h401, 4'd3, 20'h8001, 3'b011);
    repeat (N + 2) idle();

    // random phase, tagged then untagged (R1-R11 against the model)
    for (int ph = 0; ph < 2; ph++) begin
      ctx = (ph == 0) ? "R9" : "R10";
      do_flush();
      cfg_pid_match = (ph == 0);
      for (int k = 0; k < 5000; k++) begin
        logic [VW-1:0] fv;
        logic [PW-1:0] fp;
        idle_in();
        if (($urandom % 64) == 0) flush = 1;
        if (($urandom % 4) != 0) begin
          lk_valid = 1; lk_vpn = VW'($urandom % 16); lk_pid = PW'($urandom % 4);
          lk_write = $urandom % 2;
        end
        fv = VW'($urandom % 16);
        fp = PW'($urandom % 4);
        if (($urandom % 4) == 0 && !present(fv, fp)) begin
          fill_valid = 1; fill_vpn = fv; fill_pid = fp;
          fill_pfn = FW'($urandom); fill_prot = RW'($urandom);
        end
        tick();
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule